// File: doc/BRIEF.md
# Flash Protected Range Checker

This block guards a serial flash against unwanted accesses. It holds five protection range registers. Each one describes a window of the 25-bit flash address space at 4 KB page granularity, and each has its own enable for reads and its own enable for writes and erases. Every access the flash sequencer is about to issue is presented on a one-cycle request strobe. One clock later the block answers with a blocked flag and the index of the range that caused the block.

Firmware programs the ranges while the block is unlocked, then pulses a lockdown strobe. The lockdown does two things. It switches enforcement on, and it freezes the range registers until the next reset. Before lockdown, no access is ever blocked, so the ranges can be staged freely.

Top module: `flash_range_guard`

## Requirements
- R1: After reset, every range register reads as zero, the block is unlocked, and `resValid` and `blocked` are low with `hitIdx` zero.
- R2: A write with `regWrEn` high and `regWrIdx` in 0..4 loads that range register. Bits 30:29 and 14:13 always read as zero whatever was written. Writes to indices 5..7 are ignored, and reads of indices 5..7 return zero. `regRdData` follows `regRdIdx` combinationally.
- R3: A `lockStrobe` pulse sets a lock that stays set until reset. A write in the same cycle as the strobe still lands. Writes in any later cycle leave every register unchanged. After a reset the registers are writable again.
- R4: While unlocked, no access is blocked, whatever the register contents.
- R5: Register layout: bit 31 is the write/erase protect enable, bit 15 is the read protect enable, bits 28:16 hold the upper page (address bits 24:12), and bits 12:0 hold the lower page. A request with `reqIsWrite`=1 (write or erase) is checked only against bit 31. A request with `reqIsWrite`=0 (read) is checked only against bit 15.
- R6: A range matches address A when {lower,12'h000} <= A <= {upper,12'hFFF}. Both ends are inclusive.
- R7: A range whose lower page is above its upper page never matches.
- R8: When several enabled ranges match, `hitIdx` reports the lowest index. `hitIdx` is zero whenever `blocked` is low.
- R9: `resValid` is high in exactly the cycle after each cycle in which `reqValid` was sampled high, and `blocked` and `hitIdx` are valid in that cycle. `blocked` is low whenever `resValid` is low. Back-to-back requests each get their own result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regWrEn | input | 1 | Range register write strobe |
| regWrIdx | input | 3 | Index of the register to write |
| regWrData | input | 32 | Write data |
| regRdIdx | input | 3 | Index of the register to read |
| regRdData | output | 32 | Read data, combinational |
| lockStrobe | input | 1 | Lockdown pulse |
| reqValid | input | 1 | Access request strobe |
| reqAddr | input | 25 | Access address |
| reqIsWrite | input | 1 | 1 = write or erase, 0 = read |
| resValid | output | 1 | Result valid, one cycle after the request |
| blocked | output | 1 | Access hits an enabled range |
| hitIdx | output | 3 | Lowest matching range index |

## Verification
The assertions assume that the inputs are driven only between clock edges and that `regRdIdx` is held while a frozen register is compared across cycles. The lock-freeze property only fires when the index is unchanged. The bench changes every input at the falling edge and holds the read index steady during each read check. It also keeps a register model that follows the write, reserved-bit and lock rules, so the expected result of each request is derived from the requirements rather than from the design.

// File: rtl/frg_pkg.sv
`timescale 1ns/1ps
package frg_pkg;
  parameter int NUM_RANGES = 5;
  parameter int ADDR_W     = 25;
  parameter int PAGE_W     = 12;
  parameter int REG_W      = 32;
  parameter int WP_BIT     = 31;
  parameter int RP_BIT     = 15;
  parameter int UPPER_LSB  = 16;
  parameter int LOWER_LSB  = 0;

  localparam int LIMIT_W = ADDR_W - PAGE_W;
  localparam int IDX_W   = $clog2(NUM_RANGES);
  localparam logic [REG_W-1:0] LIM_ONES  = REG_W'((1 << LIMIT_W) - 1);
  localparam logic [REG_W-1:0] KEEP_MASK = (REG_W'(1) << WP_BIT) | (REG_W'(1) << RP_BIT)
                                         | (LIM_ONES << UPPER_LSB) | (LIM_ONES << LOWER_LSB);

  typedef struct packed {
    logic [NUM_RANGES-1:0] wrSel;
    logic                  capReq;
    logic                  locked;
  } ctlStrobes_t;
endpackage

// File: rtl/frg_ctrl.sv
`timescale 1ns/1ps
module frg_ctrl
  import frg_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             regWrEn,
  input  logic [IDX_W-1:0] regWrIdx,
  input  logic             lockStrobe,
  input  logic             reqValid,
  output ctlStrobes_t      ctl,
  output logic             resValid
);
  logic lockedQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      lockedQ  <= 1'b0;
      resValid <= 1'b0;
    end else begin
      if (lockStrobe) lockedQ <= 1'b1;
      resValid <= reqValid;
    end
  end

  for (genvar i = 0; i < NUM_RANGES; i++) begin : g_sel
    assign ctl.wrSel[i] = regWrEn && !lockedQ && (regWrIdx == IDX_W'(i));
  end

  assign ctl.capReq = reqValid;
  assign ctl.locked = lockedQ;
endmodule

// File: rtl/frg_datapath.sv
`timescale 1ns/1ps
module frg_datapath
  import frg_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  ctlStrobes_t       ctl,
  input  logic [REG_W-1:0]  regWrData,
  input  logic [IDX_W-1:0]  regRdIdx,
  output logic [REG_W-1:0]  regRdData,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic              reqIsWrite,
  input  logic              resValid,
  output logic              blocked,
  output logic [IDX_W-1:0]  hitIdx
);
  logic [REG_W-1:0]      rangeReg [NUM_RANGES];
  logic [ADDR_W-1:0]     addrQ;
  logic                  isWrQ;
  logic [NUM_RANGES-1:0] match;
  logic [IDX_W-1:0]      firstIdx;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < NUM_RANGES; i++) rangeReg[i] <= '0;
      addrQ <= '0;
      isWrQ <= 1'b0;
    end else begin
      for (int i = 0; i < NUM_RANGES; i++)
        if (ctl.wrSel[i]) rangeReg[i] <= regWrData & KEEP_MASK;
      if (ctl.capReq) begin
        addrQ <= reqAddr;
        isWrQ <= reqIsWrite;
      end
    end
  end

  always_comb begin
    regRdData = '0;
    for (int i = 0; i < NUM_RANGES; i++)
      if (regRdIdx == IDX_W'(i)) regRdData = rangeReg[i];
  end

  for (genvar i = 0; i < NUM_RANGES; i++) begin : g_cmp
    logic [LIMIT_W-1:0] upPage, loPage;
    logic [ADDR_W-1:0]  loAddr, hiAddr;
    logic               enSel;
    assign upPage = rangeReg[i][UPPER_LSB +: LIMIT_W];
    assign loPage = rangeReg[i][LOWER_LSB +: LIMIT_W];
    assign loAddr = {loPage, {PAGE_W{1'b0}}};
    assign hiAddr = {upPage, {PAGE_W{1'b1}}};
    assign enSel  = isWrQ ? rangeReg[i][WP_BIT] : rangeReg[i][RP_BIT];
    assign match[i] = enSel && (addrQ >= loAddr) && (addrQ <= hiAddr);
  end

  always_comb begin
    firstIdx = '0;
    for (int i = NUM_RANGES - 1; i >= 0; i--)
      if (match[i]) firstIdx = IDX_W'(i);
  end

  assign blocked = resValid && ctl.locked && (|match);
  assign hitIdx  = blocked ? firstIdx : '0;
endmodule

// File: rtl/flash_range_guard.sv
`timescale 1ns/1ps
module flash_range_guard
  import frg_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic [IDX_W-1:0]  regWrIdx,
  input  logic [REG_W-1:0]  regWrData,
  input  logic [IDX_W-1:0]  regRdIdx,
  output logic [REG_W-1:0]  regRdData,
  input  logic              lockStrobe,
  input  logic              reqValid,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic              reqIsWrite,
  output logic              resValid,
  output logic              blocked,
  output logic [IDX_W-1:0]  hitIdx
);
  ctlStrobes_t ctl;

  frg_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regWrIdx(regWrIdx),
    .lockStrobe(lockStrobe), .reqValid(reqValid), .ctl(ctl), .resValid(resValid)
  );

  frg_datapath u_dp (
    .clk(clk), .rstN(rstN), .ctl(ctl), .regWrData(regWrData),
    .regRdIdx(regRdIdx), .regRdData(regRdData), .reqAddr(reqAddr),
    .reqIsWrite(reqIsWrite), .resValid(resValid), .blocked(blocked), .hitIdx(hitIdx)
  );
endmodule

// File: rtl/frg_checker.sv
`timescale 1ns/1ps
module frg_checker
  import frg_pkg::*;
(
  input logic             clk,
  input logic             rstN,
  input logic [IDX_W-1:0] regRdIdx,
  input logic [REG_W-1:0] regRdData,
  input logic             lockStrobe,
  input logic             reqValid,
  input logic             resValid,
  input logic             blocked,
  input logic [IDX_W-1:0] hitIdx
);
  logic lockSeen;
  always_ff @(posedge clk) begin
    if (!rstN) lockSeen <= 1'b0;
    else if (lockStrobe) lockSeen <= 1'b1;
  end

  // R2: reserved fields never read back as one
  p_reserved_zero_r2: assert property (@(posedge clk) disable iff (!rstN)
    regRdData[30:29] == 2'b00 && regRdData[14:13] == 2'b00);

  // R3: contents frozen once the lock has been in place for a full cycle
  p_lock_freeze_r3: assert property (@(posedge clk) disable iff (!rstN)
    (lockSeen && $past(lockSeen) && regRdIdx == $past(regRdIdx)) |-> regRdData == $past(regRdData));

  // R4: no block before lockdown
  p_no_block_unlocked_r4: assert property (@(posedge clk) disable iff (!rstN)
    blocked |-> lockSeen);

  // R8: index zero when not blocked, and always in range
  p_idx_idle_r8: assert property (@(posedge clk) disable iff (!rstN)
    !blocked |-> hitIdx == '0);
  p_idx_range_r8: assert property (@(posedge clk) disable iff (!rstN)
    hitIdx < IDX_W'(NUM_RANGES));

  // R9: one result per request, exactly one cycle later
  p_result_follows_r9: assert property (@(posedge clk) disable iff (!rstN)
    reqValid |=> resValid);
  p_no_spurious_r9: assert property (@(posedge clk) disable iff (!rstN)
    !reqValid |=> !resValid);
  p_blocked_valid_r9: assert property (@(posedge clk) disable iff (!rstN)
    blocked |-> resValid);
endmodule

bind flash_range_guard frg_checker u_frg_checker (
  .clk(clk), .rstN(rstN), .regRdIdx(regRdIdx), .regRdData(regRdData),
  .lockStrobe(lockStrobe), .reqValid(reqValid), .resValid(resValid),
  .blocked(blocked), .hitIdx(hitIdx)
);

// File: tb/flash_range_guard_bench.sv
`timescale 1ns/1ps
module flash_range_guard_bench;
  import frg_pkg::*;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic regWrEn = 1'b0;
  logic [2:0] regWrIdx = '0;
  logic [31:0] regWrData = '0;
  logic [2:0] regRdIdx = '0;
  logic [31:0] regRdData;
  logic lockStrobe = 1'b0;
  logic reqValid = 1'b0;
  logic [24:0] reqAddr = '0;
  logic reqIsWrite = 1'b0;
  logic resValid, blocked;
  logic [2:0] hitIdx;

  always #2 clk = ~clk;

  flash_range_guard u_flash_range_guard (.*);

  int total = 0;
  int bad = 0;

  typedef struct {
    logic       blk;
    logic [2:0] idx;
    string      tag;
  } expItem_t;
  expItem_t expQ[$];

  logic [31:0] mdl [5];
  logic mdlLocked = 1'b0;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // expected result from the R5..R8 rules
  function automatic void refCheck(input logic [24:0] a, input logic wr,
                                   output logic blk, output logic [2:0] idx);
    blk = 1'b0; idx = '0;
    for (int i = 4; i >= 0; i--) begin
      logic en;
      logic [24:0] lo, hi;
      en = wr ? mdl[i][31] : mdl[i][15];
      lo = {mdl[i][12:0], 12'h000};
      hi = {mdl[i][28:16], 12'hFFF};
      if (en && a >= lo && a <= hi) begin blk = 1'b1; idx = 3'(i); end
    end
    if (!mdlLocked) begin blk = 1'b0; idx = '0; end
  endfunction

  task automatic wrReg(input int idx, input logic [31:0] d, input logic withLock);
    regWrEn = 1'b1; regWrIdx = 3'(idx); regWrData = d; lockStrobe = withLock;
    @(negedge clk);
    regWrEn = 1'b0; lockStrobe = 1'b0;
    if (!mdlLocked && idx < 5) mdl[idx] = d & 32'h9FFF9FFF;
    if (withLock) mdlLocked = 1'b1;
  endtask

  task automatic rdReg(input int idx, input string tag);
    regRdIdx = 3'(idx);
    #1;
    chk(tag, regRdData, (idx < 5) ? mdl[idx] : 32'h0);
  endtask

  task automatic access(input logic [24:0] a, input logic wr, input string tag);
    expItem_t it;
    refCheck(a, wr, it.blk, it.idx);
    it.tag = tag;
    expQ.push_back(it);
    reqValid = 1'b1; reqAddr = a; reqIsWrite = wr;
    @(negedge clk);
    reqValid = 1'b0;
  endtask

  task automatic doReset();
    rstN = 1'b0;
    repeat (2) @(negedge clk);
    for (int i = 0; i < 5; i++) mdl[i] = '0;
    mdlLocked = 1'b0;
    rstN = 1'b1;
  endtask

  // monitor: compare each result against the queue head
  always @(negedge clk) begin
    if (rstN) begin
      if (resValid) begin
        if (expQ.size() == 0) begin
          chk("R9 unexpected result", 32'(resValid), 32'h0);
        end else begin
          expItem_t it;
          it = expQ.pop_front();
          chk({it.tag, " blocked"}, 32'(blocked), 32'(it.blk));
          chk({it.tag, " hitIdx"}, 32'(hitIdx), 32'(it.idx));
        end
      end else begin
        chk("R9 blocked without result", 32'(blocked), 32'h0);
      end
    end
  end

  initial begin
    #400000;
    bad++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    for (int i = 0; i < 5; i++) mdl[i] = '0;
    @(negedge clk);
    doReset();
    // R1 reset state
    chk("R1 resValid", 32'(resValid), 32'h0);
    chk("R1 blocked", 32'(blocked), 32'h0);
    for (int i = 0; i < 8; i++) rdReg(i, "R1 reg after reset");

    // R2 reserved bits and out-of-range index
    wrReg(0, 32'hFFFF_FFFF, 1'b0);
    rdReg(0, "R2 reserved bits zero");
    chk("R2 mask value", regRdData, 32'h9FFF_9FFF);
    wrReg(6, 32'hFFFF_FFFF, 1'b0);
    rdReg(6, "R2 index 6 ignored");

    // ranges: r0 WP page 0x10; r1 RP 0x08..0x1F; r2 inverted; r3 WP 0x0C..0x12
    wrReg(0, 32'h8010_0010, 1'b0);
    wrReg(1, 32'h001F_8008, 1'b0);
    wrReg(2, 32'h8030_8040, 1'b0);
    wrReg(3, 32'h8012_000C, 1'b0);
    for (int i = 0; i < 4; i++) rdReg(i, "R2 readback");

    // R4 nothing blocked while unlocked
    access(25'h0_10000, 1'b1, "R4 unlocked write");
    access(25'h0_10000, 1'b0, "R4 unlocked read");

    // R3 write in the lock cycle lands; r4 covers top page for both kinds
    wrReg(4, 32'h9FFF_9FFF, 1'b1);
    rdReg(4, "R3 write with lock lands");
    wrReg(0, 32'h0000_0000, 1'b0);
    rdReg(0, "R3 write after lock ignored");

    // R6 inclusive bounds
    access(25'h0_10000, 1'b1, "R6 lower edge");
    access(25'h0_10FFF, 1'b1, "R6 upper edge");
    // R8 overlap lowest index, R9 back-to-back
    access(25'h0_10800, 1'b1, "R8 overlap lowest");
    access(25'h0_0FFFF, 1'b1, "R6 below r0 hits r3");
    access(25'h0_11000, 1'b1, "R6 above r0 hits r3");
    access(25'h0_13000, 1'b1, "R6 outside all");
    // R5 kind selects the enable
    access(25'h0_10000, 1'b0, "R5 read uses read enable");
    access(25'h0_09000, 1'b1, "R5 write ignores read-only range");
    access(25'h0_07FFF, 1'b0, "R5 read below r1");
    // R7 inverted range
    access(25'h0_35000, 1'b1, "R7 inverted write");
    access(25'h0_45000, 1'b0, "R7 inverted read");
    access(25'h1FF_FFFF, 1'b1, "R5 top page write");
    access(25'h1FF_F000, 1'b0, "R5 top page read");
    @(negedge clk);
    access(25'h0_00000, 1'b1, "R9 isolated request");
    repeat (3) @(negedge clk);
    chk("R9 all results seen", 32'(expQ.size()), 32'h0);

    // R3 reset clears lock and registers
    doReset();
    rdReg(0, "R3 reset clears reg");
    wrReg(0, 32'h8010_0010, 1'b0);
    rdReg(0, "R3 writable after reset");
    access(25'h0_10000, 1'b1, "R4 unlocked again");
    repeat (2) @(negedge clk);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule